// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog timer with a small 16-bit register port. A down-counter steps once for each cycle in which the tick-enable input is high, unless the halt control bit is set. When the counter expires for the first time, the block raises a first-timeout flag and reloads the counter from a programmable initial value. If that flag is still set when the counter expires a second time, the block raises a second-timeout flag. It also sends a one-cycle system reset request, unless the no-reboot control bit blocks it.

Software services the watchdog by writing the reload value to the count register and clearing the first-timeout flag by writing 1 to it. After servicing, two more unserviced expiries are needed before a reset request is sent. The tick prescaler is outside the block. With a nominal 0.6 s tick, a timeout of S seconds corresponds to S×10/6 ticks. Register reads have one cycle of latency: the read data register captures the addressed value on every clock edge.

Top module: `wdog_twostage`

## Requirements
- R1: After a synchronous reset the block is in this state. The initial-value register (offset 0x12) holds 0x0004 and the count is 4. The halt bit (offset 0x08 bit 11) is 1 and the no-reboot bit (offset 0x08 bit 0) is 0. Both timeout flags are 0 and reset_req is low.
- R2: While halt is 0, each cycle with tick_en high lowers a nonzero count by one. While halt is 1, or tick_en is low, the count holds.
- R3: Writing exactly 0x0001 to offset 0x00 loads the count from bits 9:0 of the initial-value register. This load takes priority over a tick in the same cycle. Writing any other value to offset 0x00 has no effect.
- R4: reg_rdata is registered. One cycle after an address is presented, it shows that register's contents as they were before that edge. Offset 0x00 reads the count in bits 9:0, with bits 15:10 reading zero.
- R5: A write to offset 0x12 whose bits 9:0 are 4 or more stores all 16 bits, and bits 15:10 read back as written. A write whose bits 9:0 are 0 to 3 is ignored entirely, and the previous value is kept.
- R6: A tick (with halt 0) on a count of 0 while the first-timeout flag (offset 0x04 bit 3) is clear sets that flag and reloads the count from the initial value.
- R7: A tick (with halt 0) on a count of 0 while the first-timeout flag is set does three things. It sets the second-timeout flag (offset 0x06 bit 1) and reloads the count. When no-reboot is 0, it also raises reset_req for exactly one cycle, in the cycle after that edge.
- R8: While no-reboot is 1, a second expiry still sets the second-timeout flag, but reset_req stays low.
- R9: Both timeout flags are cleared by writing 1 to their bit. Writing 0 leaves them unchanged. If an expiry sets a flag in the same cycle as a clear, the set wins.
- R10: Reads of offsets other than 0x00, 0x04, 0x06, 0x08 and 0x12 return 0. Writes to those offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle count enable from the external prescaler |
| reg_addr | input | 5 | Register byte offset |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
The assertions assume three things about the inputs. A write strobe lasts one cycle per access. tick_en arrives as isolated cycles. Every input is stable between clock edges. The floor on initial values keeps any reload at 4 or more, so two expiries are always at least five ticks apart.

The stimulus drives each input once per cycle, away from the sampling edge, and pulses ticks on alternate cycles. It also switches ticking off around every read, so that each flag and count is held still while it is sampled. A behavioural model in the bench predicts reg_rdata and reset_req on every clock.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] word_t;

  localparam addr_t ADDR_CNT  = 5'h00;
  localparam addr_t ADDR_ST1  = 5'h04;
  localparam addr_t ADDR_ST2  = 5'h06;
  localparam addr_t ADDR_CTRL = 5'h08;
  localparam addr_t ADDR_INIT = 5'h12;

  localparam int BIT_HALT = 11;
  localparam int BIT_NRB  = 0;
  localparam int BIT_TO1  = 3;
  localparam int BIT_TO2  = 1;

  localparam word_t RELOAD_KEY = 16'h0001;
endpackage

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W    = 10,
  parameter int INIT_RST = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic             reload,
  input  logic [CNT_W-1:0] init_lo,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);
  localparam logic [CNT_W-1:0] CNT_RST = CNT_W'(INIT_RST);

  logic at_zero;
  assign at_zero = (cnt_q == '0);
  assign expire  = tick & run & at_zero & ~reload;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= CNT_RST;
    end else if (reload) begin
      cnt_q <= init_lo;
    end else if (tick && run) begin
      cnt_q <= at_zero ? init_lo : cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int INIT_RST = 4,
  parameter int INIT_MIN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  addr_t            addr,
  input  logic             we,
  input  word_t            wdata,
  input  logic             expire,
  input  logic [CNT_W-1:0] cnt,
  output word_t            init_q,
  output logic             halt_q,
  output logic             nrb_q,
  output logic             to1_q,
  output logic             to2_q,
  output word_t            rdata,
  output logic             reset_req
);
  localparam int PAD_W = DATA_W - CNT_W;
  localparam word_t INIT_RV = DATA_W'(INIT_RST);
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(INIT_MIN);

  logic wr_init, wr_ctrl, clr_to1, clr_to2, init_ok;
  logic to1_n, to2_n;
  word_t rd_mux;

  assign wr_init = we && (addr == ADDR_INIT);
  assign wr_ctrl = we && (addr == ADDR_CTRL);
  assign clr_to1 = we && (addr == ADDR_ST1) && wdata[BIT_TO1];
  assign clr_to2 = we && (addr == ADDR_ST2) && wdata[BIT_TO2];
  assign init_ok = (wdata[CNT_W-1:0] >= MIN_V);

  // An expiry's set takes priority over a same-cycle clear.
  always_comb begin
    to1_n = clr_to1 ? 1'b0 : to1_q;
    to2_n = clr_to2 ? 1'b0 : to2_q;
    if (expire && !to1_q) to1_n = 1'b1;
    if (expire &&  to1_q) to2_n = 1'b1;
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      ADDR_CNT:  rd_mux = {{PAD_W{1'b0}}, cnt};
      ADDR_ST1:  rd_mux[BIT_TO1] = to1_q;
      ADDR_ST2:  rd_mux[BIT_TO2] = to2_q;
      ADDR_CTRL: begin
        rd_mux[BIT_HALT] = halt_q;
        rd_mux[BIT_NRB]  = nrb_q;
      end
      ADDR_INIT: rd_mux = init_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      init_q    <= INIT_RV;
      halt_q    <= 1'b1;
      nrb_q     <= 1'b0;
      to1_q     <= 1'b0;
      to2_q     <= 1'b0;
      rdata     <= '0;
      reset_req <= 1'b0;
    end else begin
      if (wr_init && init_ok) init_q <= wdata;
      if (wr_ctrl) begin
        halt_q <= wdata[BIT_HALT];
        nrb_q  <= wdata[BIT_NRB];
      end
      to1_q     <= to1_n;
      to2_q     <= to2_n;
      rdata     <= rd_mux;
      reset_req <= expire & to1_q & ~nrb_q;
    end
  end
endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage
  import wdt_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int INIT_RST = 4,
  parameter int INIT_MIN = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick_en,
  input  logic [4:0]  reg_addr,
  input  logic        reg_we,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        reset_req
);
  word_t            init_q;
  logic             halt_q, nrb_q, to1_q, to2_q;
  logic [CNT_W-1:0] cnt_q;
  logic             expire, reload_wr;

  assign reload_wr = reg_we && (reg_addr == ADDR_CNT) && (reg_wdata == RELOAD_KEY);

  wdt_counter #(.CNT_W(CNT_W), .INIT_RST(INIT_RST)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick_en),
    .run     (~halt_q),
    .reload  (reload_wr),
    .init_lo (init_q[CNT_W-1:0]),
    .cnt_q   (cnt_q),
    .expire  (expire)
  );

  wdt_regs #(.CNT_W(CNT_W), .INIT_RST(INIT_RST), .INIT_MIN(INIT_MIN)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .addr      (reg_addr),
    .we        (reg_we),
    .wdata     (reg_wdata),
    .expire    (expire),
    .cnt       (cnt_q),
    .init_q    (init_q),
    .halt_q    (halt_q),
    .nrb_q     (nrb_q),
    .to1_q     (to1_q),
    .to2_q     (to2_q),
    .rdata     (reg_rdata),
    .reset_req (reset_req)
  );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import wdt_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int INIT_MIN = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_en,
  input logic             reg_we,
  input logic [4:0]       reg_addr,
  input logic [15:0]      reg_wdata,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] init_lo,
  input logic             halt,
  input logic             nrb,
  input logic             to1,
  input logic             to2,
  input logic             reset_req
);
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(INIT_MIN);
  logic rl;
  assign rl = reg_we && (reg_addr == ADDR_CNT) && (reg_wdata == RELOAD_KEY);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    reset_req |=> !reset_req);
  a_r7_second_flag: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> to2);
  a_r8_noreboot_gate: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> $past(!nrb));
  a_r2_halt_freeze: assert property (@(posedge clk) disable iff (rst)
    (halt && !rl) |=> $stable(cnt));
  a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !halt && cnt != '0 && !rl) |=> (cnt == $past(cnt) - 1'b1));
  a_r6_first_flag: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !halt && cnt == '0 && !rl) |=> to1);
  a_r5_init_floor: assert property (@(posedge clk) disable iff (rst)
    init_lo >= MIN_V);
endmodule

bind wdog_twostage wdt_checker #(.CNT_W(CNT_W), .INIT_MIN(INIT_MIN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick_en   (tick_en),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .cnt       (cnt_q),
  .init_lo   (init_q[CNT_W-1:0]),
  .halt      (halt_q),
  .nrb       (nrb_q),
  .to1       (to1_q),
  .to2       (to2_q),
  .reset_req (reset_req)
);

// File: tb/wdog_twostage_test.sv
module wdog_twostage_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tb_tick = 1'b0;
  logic        tick_on = 1'b0;
  logic [4:0]  tb_addr = '0;
  logic        tb_we = 1'b0;
  logic [15:0] tb_wdata = '0;
  logic [15:0] rdata;
  logic        req;

  int n_tests = 0;
  int n_fail = 0;
  int n_req = 0;
  int cycles = 0;
  logic prev_req = 1'b0;

  // reference state
  int   m_cnt, m_init;
  logic m_halt, m_nrb, m_to1, m_to2, m_req;
  logic [15:0] m_rd;

  always #2 clk = ~clk;

  wdog_twostage uut (
    .clk(clk), .rst(rst), .tick_en(tb_tick), .reg_addr(tb_addr),
    .reg_we(tb_we), .reg_wdata(tb_wdata), .reg_rdata(rdata), .reset_req(req)
  );

  function automatic logic [15:0] m_read(input logic [4:0] a);
    case (a)
      5'h00: return 16'(m_cnt);
      5'h04: return m_to1 ? 16'h0008 : 16'h0000;
      5'h06: return m_to2 ? 16'h0002 : 16'h0000;
      5'h08: return {4'b0, m_halt, 10'b0, m_nrb};
      5'h12: return 16'(m_init);
      default: return 16'h0000;
    endcase
  endfunction

  always @(posedge clk) begin
    logic rl, ex, o1, o2;
    if (rst) begin
      m_cnt = 4; m_init = 4; m_halt = 1; m_nrb = 0;
      m_to1 = 0; m_to2 = 0; m_req = 0; m_rd = 0;
    end else begin
      m_rd = m_read(tb_addr);
      rl = tb_we && tb_addr == 5'h00 && tb_wdata == 16'h0001;
      ex = tb_tick && !m_halt && m_cnt == 0 && !rl;
      o1 = m_to1; o2 = m_to2;
      m_req = ex && o1 && !m_nrb;
      if (tb_we && tb_addr == 5'h04 && tb_wdata[3]) m_to1 = 0;
      if (tb_we && tb_addr == 5'h06 && tb_wdata[1]) m_to2 = 0;
      if (ex && !o1) m_to1 = 1;
      if (ex && o1) m_to2 = 1;
      if (rl) m_cnt = m_init & 16'h03FF;
      else if (tb_tick && !m_halt) m_cnt = (m_cnt == 0) ? (m_init & 16'h03FF) : m_cnt - 1;
      if (tb_we && tb_addr == 5'h12 && (tb_wdata & 16'h03FF) >= 4) m_init = tb_wdata;
      if (tb_we && tb_addr == 5'h08) begin m_halt = tb_wdata[11]; m_nrb = tb_wdata[0]; end
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model, plus pulse bookkeeping
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      check(req == m_req, "R7 reset_req vs model", req, m_req);
      check(rdata == m_rd, "R4 reg_rdata vs model", rdata, m_rd);
      check(!(req && prev_req), "R7 pulse width", 2, 1);
      if (req) n_req++;
    end
    prev_req = req;
    tb_tick = tick_on ? ~tb_tick : 1'b0;
    if (cycles > 20000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); tb_addr = a; tb_we = 1'b1; tb_wdata = d;
    @(negedge clk); tb_we = 1'b0; tb_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk); tb_addr = a; tb_we = 1'b0;
    @(negedge clk);
    #1 check(rdata == exp, tag, rdata, exp);
  endtask

  task automatic run_ticks(input int n);
    @(negedge clk); tick_on = 1'b1;
    repeat (n) @(negedge clk);
    tick_on = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [15:0] v;
    int base;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(5'h00, 16'h0004, "R1 count after reset");
    rd(5'h12, 16'h0004, "R1 init after reset");
    rd(5'h08, 16'h0800, "R1 control after reset");
    rd(5'h04, 16'h0000, "R1 first flag after reset");
    rd(5'h06, 16'h0000, "R1 second flag after reset");
    check(req == 1'b0, "R1 reset_req low", req, 0);
    // R10 unmapped
    rd(5'h02, 16'h0000, "R10 unmapped read 0x02");
    wr(5'h0A, 16'hFFFF);
    wr(5'h02, 16'h0001);
    rd(5'h0A, 16'h0000, "R10 unmapped read 0x0A");
    rd(5'h08, 16'h0800, "R10 control untouched");
    rd(5'h12, 16'h0004, "R10 init untouched");
    // R5 init floor and upper bits
    wr(5'h12, 16'h0003);
    rd(5'h12, 16'h0004, "R5 illegal init ignored");
    wr(5'h12, 16'hA405);
    rd(5'h12, 16'hA405, "R5 legal init stored with upper bits");
    wr(5'h12, 16'hFC00);
    rd(5'h12, 16'hA405, "R5 zero init ignored");
    // R3 reload key
    wr(5'h00, 16'h0002);
    rd(5'h00, 16'h0004, "R3 non-key write ignored");
    wr(5'h00, 16'h0001);
    rd(5'h00, 16'h0005, "R3 reload from init");
    // R2 halt holds, run counts
    run_ticks(10);
    rd(5'h00, 16'h0005, "R2 halted count holds");
    wr(5'h08, 16'h0000);
    run_ticks(6);
    @(negedge clk); tb_addr = 5'h00; @(negedge clk); #1 v = rdata;
    check(v < 16'h0005 && v > 16'h0000, "R2 count decreased", v, 3);
    // R6 first expiry
    wr(5'h00, 16'h0001);
    base = n_req;
    run_ticks(14);
    rd(5'h04, 16'h0008, "R6 first flag set");
    rd(5'h06, 16'h0000, "R6 second flag clear");
    check(n_req == base, "R6 no reset request", n_req - base, 0);
    // R7 second expiry
    run_ticks(14);
    rd(5'h06, 16'h0002, "R7 second flag set");
    check(n_req == base + 1, "R7 one reset request", n_req - base, 1);
    // R9 write-1-to-clear
    wr(5'h04, 16'h0000);
    rd(5'h04, 16'h0008, "R9 write 0 keeps flag");
    wr(5'h04, 16'h0008);
    rd(5'h04, 16'h0000, "R9 first flag cleared");
    wr(5'h06, 16'h0002);
    rd(5'h06, 16'h0000, "R9 second flag cleared");
    // R8 no-reboot gate
    wr(5'h08, 16'h0001);
    rd(5'h08, 16'h0001, "R8 control readback");
    wr(5'h00, 16'h0001);
    base = n_req;
    run_ticks(28);
    rd(5'h06, 16'h0002, "R8 second flag still set");
    check(n_req == base, "R8 reset request blocked", n_req - base, 0);
    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule